// File: doc/BRIEF.md
# Serialized Instruction Completion Gating

This block is the gate at the completion end of an in-order instruction queue. Each entry arrives from a dispatch port in program order. Each entry carries one of four serialization classes and an optional oldest-slot restriction. The execution units report finished entries by slot tag. Each cycle the block decides three things: which entries may start executing, how many of the oldest entries complete, and whether a completing entry forces the younger instructions to be discarded and fetched again.

A move-to entry is held back until it has been the oldest entry for a full cycle. A store entry may execute whenever it likes, but it is only committed to memory when it completes. At most one store completes in a cycle. A refetch entry completes last in its cycle, empties the queue of everything younger, and points fetch at the instruction that follows it.

The head tracker is a three-state machine:
- `HS_EMPTY`: the queue holds nothing.
- `HS_FRESH`: the current oldest entry became oldest at the last clock edge.
- `HS_AGED`: the oldest entry has stayed oldest for at least one full cycle.

Its transitions are:
- From `HS_EMPTY` to `HS_FRESH` when an entry is allocated.
- From `HS_FRESH` to `HS_AGED` when the oldest entry does not change.
- From `HS_FRESH` or `HS_AGED` to `HS_FRESH` whenever entries retire and others remain.
- From any state to `HS_EMPTY` when the queue drains or is flushed.

Top module: `cq_serial_gate`

## Requirements
- R1: After reset the queue is empty, `disp_ready` is 1, and `exec_en`, `cmp_count`, `store_commit` and `flush_req` are all 0.
- R2: Class codes are 0 = none, 1 = move-to, 2 = refetch, 3 = store. A dispatch is accepted when `disp_valid` and `disp_ready` are both 1. Slots are handed out in ring order starting at 0, and `disp_tag` gives the slot. `disp_ready` is 0 when all slots are full and in any cycle with `flush_req` high.
- R3: An entry of class none, refetch or store has its `exec_en` bit set in every cycle it is present and not yet finished. A waiting store does not hold back other entries.
- R4: A move-to entry has `exec_en` set only while it is oldest, and only from the second cycle it has been oldest.
- R5: Completion is in order, at most two entries per cycle, and stops at the first entry that has not finished. `cmp_count` gives the number that complete.
- R6: At most one store completes per cycle. A non-store entry still completes alongside it.
- R7: A store entry marked oldest-only completes only from the oldest slot.
- R8: `store_commit` is 1 exactly in a cycle in which a store entry completes.
- R9: When a refetch entry completes, nothing younger completes in that cycle. `flush_req` is 1 and `flush_pc` equals that entry's address plus 4. All younger entries are discarded, so the next dispatch goes to the slot after the refetch entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_class | input | 2 | Serialization class of the dispatched entry |
| disp_oldest_only | input | 1 | Store may complete only from the oldest slot |
| disp_pc | input | 32 | Instruction address of the dispatched entry |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag | output | 3 | Slot that a dispatch in this cycle occupies |
| fin_valid | input | 1 | An execution unit reports a finished entry |
| fin_tag | input | 3 | Slot of the finished entry |
| exec_en | output | 8 | Per-slot permission to start execution |
| cmp_count | output | 2 | Entries completing this cycle |
| store_commit | output | 1 | A store completes and may be written to memory |
| flush_req | output | 1 | Discard younger entries and refetch |
| flush_pc | output | 32 | Address to refetch from |

## Verification
Some rules are checked by assertions on every cycle:
- Completion never starts at an unfinished or empty oldest slot.
- Two stores never complete together.
- An oldest-only store never completes from the second slot.
- A commit strobe always comes with a completion.
- A full queue refuses dispatch.
- A flush leaves the queue empty.
- A move-to entry only starts after a cycle of being oldest with no retirement.

Other behaviour needs the bench's scenarios. These are:
- the exact cycle at which a move-to entry gains its enable;
- the refetch address from either completion position;
- slot reuse after a flush;
- the execute-enable pattern while stores wait.

// File: rtl/cq_gate_pkg.sv
package cq_gate_pkg;

    typedef enum logic [1:0] {
        SC_NONE    = 2'd0,
        SC_MOVETO  = 2'd1,
        SC_REFETCH = 2'd2,
        SC_STORE   = 2'd3
    } ser_class_e;

    typedef enum logic [1:0] {
        HS_EMPTY = 2'd0,
        HS_FRESH = 2'd1,
        HS_AGED  = 2'd2
    } head_state_e;

    // Ring pointer advance by n slots, depth need not be a power of two.
    function automatic int ring_add(input int p, input int n, input int depth);
        int s;
        s = p + n;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/cq_entry_store.sv
module cq_entry_store
    import cq_gate_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [1:0]               alloc_cls,
    input  logic                     alloc_only,
    input  logic [AW-1:0]            alloc_pc,
    input  logic                     fin_valid,
    input  logic [IW-1:0]            fin_idx,
    input  logic [1:0]               retire_n,
    input  logic                     flush,
    output logic [DEPTH-1:0]         valid_o,
    output logic [DEPTH-1:0]         done_o,
    output logic [DEPTH-1:0][1:0]    cls_o,
    output logic [DEPTH-1:0]         only_o,
    output logic [DEPTH-1:0][AW-1:0] pc_o,
    output logic [IW-1:0]            head_o,
    output logic [IW-1:0]            tail_o,
    output logic [CW-1:0]            count_o,
    output logic [CW-1:0]            count_nxt_o
);

    logic [DEPTH-1:0]         valid_q;
    logic [DEPTH-1:0]         done_q;
    logic [DEPTH-1:0][1:0]    cls_q;
    logic [DEPTH-1:0]         only_q;
    logic [DEPTH-1:0][AW-1:0] pc_q;
    logic [IW-1:0]            head_q;
    logic [IW-1:0]            tail_q;
    logic [CW-1:0]            count_q;
    logic [IW-1:0]            head_nxt;

    assign head_nxt    = IW'(ring_add(int'(head_q), int'(retire_n), DEPTH));
    assign count_nxt_o = flush ? '0 : (count_q - CW'(retire_n) + CW'(alloc_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            done_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            for (int r = 0; r < 2; r++) begin
                if (r < int'(retire_n)) begin
                    valid_q[IW'(ring_add(int'(head_q), r, DEPTH))] <= 1'b0;
                end
            end
            if (fin_valid && valid_q[fin_idx]) begin
                done_q[fin_idx] <= 1'b1;
            end
            if (alloc_en) begin
                valid_q[tail_q] <= 1'b1;
                done_q[tail_q]  <= 1'b0;
            end
            if (flush) begin
                valid_q <= '0;
            end
            head_q  <= head_nxt;
            tail_q  <= flush ? head_nxt
                     : alloc_en ? IW'(ring_add(int'(tail_q), 1, DEPTH)) : tail_q;
            count_q <= count_nxt_o;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            cls_q[tail_q]  <= alloc_cls;
            only_q[tail_q] <= alloc_only;
            pc_q[tail_q]   <= alloc_pc;
        end
    end

    assign valid_o = valid_q;
    assign done_o  = done_q;
    assign cls_o   = cls_q;
    assign only_o  = only_q;
    assign pc_o    = pc_q;
    assign head_o  = head_q;
    assign tail_o  = tail_q;
    assign count_o = count_q;

    // A refetch discards every younger entry: queue is empty next cycle.
    assert_flush_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && (valid_q == '0));

    // Occupancy counter and valid vector stay consistent.
    assert_count_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) == $countones(valid_q));

endmodule

// File: rtl/cq_head_fsm.sv
module cq_head_fsm
    import cq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nxt_nonempty,
    input  logic head_moves,
    output logic head_aged
);

    head_state_e hs_q, hs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= HS_EMPTY;
        else        hs_q <= hs_d;
    end

    always_comb begin
        hs_d = hs_q;
        unique case (hs_q)
            HS_EMPTY: hs_d = nxt_nonempty ? HS_FRESH : HS_EMPTY;
            HS_FRESH,
            HS_AGED: begin
                if (!nxt_nonempty)   hs_d = HS_EMPTY;
                else if (head_moves) hs_d = HS_FRESH;
                else                 hs_d = HS_AGED;
            end
            default: hs_d = HS_EMPTY;
        endcase
    end

    assign head_aged = (hs_q == HS_AGED);

    // Aged state is only reachable through a non-empty cycle.
    assert_aged_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q == HS_AGED) |-> ($past(hs_q) != HS_EMPTY));

endmodule

// File: rtl/cq_retire_logic.sv
module cq_retire_logic
    import cq_gate_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          v0,
    input  logic          f0,
    input  logic [1:0]    cls0,
    input  logic [AW-1:0] pc0,
    input  logic          v1,
    input  logic          f1,
    input  logic [1:0]    cls1,
    input  logic          only1,
    input  logic [AW-1:0] pc1,
    output logic [1:0]    retire_n,
    output logic          store_commit,
    output logic          flush,
    output logic [AW-1:0] flush_pc
);

    ser_class_e k0, k1;
    logic       c0, c1;
    logic       block1;

    assign k0 = ser_class_e'(cls0);
    assign k1 = ser_class_e'(cls1);

    always_comb begin
        c0     = v0 && f0;
        block1 = 1'b0;
        unique case (k0)
            SC_REFETCH: block1 = 1'b1;
            SC_STORE:   block1 = (k1 == SC_STORE);
            default:    block1 = 1'b0;
        endcase
        if (k1 == SC_STORE && only1) block1 = 1'b1;
        c1 = c0 && v1 && f1 && !block1;
    end

    always_comb begin
        retire_n     = {1'b0, c0} + {1'b0, c1};
        store_commit = (c0 && k0 == SC_STORE) || (c1 && k1 == SC_STORE);
        flush        = 1'b0;
        flush_pc     = '0;
        if (c1 && k1 == SC_REFETCH) begin
            flush    = 1'b1;
            flush_pc = pc1 + AW'(INSN_BYTES);
        end else if (c0 && k0 == SC_REFETCH) begin
            flush    = 1'b1;
            flush_pc = pc0 + AW'(INSN_BYTES);
        end
    end

endmodule

// File: rtl/cq_serial_gate.sv
module cq_serial_gate
    import cq_gate_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4,
    localparam int IW        = $clog2(DEPTH),
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [1:0]       disp_class,
    input  logic             disp_oldest_only,
    input  logic [AW-1:0]    disp_pc,
    output logic             disp_ready,
    output logic [IW-1:0]    disp_tag,
    input  logic             fin_valid,
    input  logic [IW-1:0]    fin_tag,
    output logic [DEPTH-1:0] exec_en,
    output logic [1:0]       cmp_count,
    output logic             store_commit,
    output logic             flush_req,
    output logic [AW-1:0]    flush_pc
);

    logic [DEPTH-1:0]         valid;
    logic [DEPTH-1:0]         done;
    logic [DEPTH-1:0][1:0]    cls;
    logic [DEPTH-1:0]         only;
    logic [DEPTH-1:0][AW-1:0] pc;
    logic [IW-1:0]            head;
    logic [IW-1:0]            tail;
    logic [IW-1:0]            pos1;
    logic [CW-1:0]            count;
    logic [CW-1:0]            count_nxt;
    logic                     alloc_en;
    logic                     head_aged;
    logic [DEPTH-1:0]         moveto_mask;

    assign pos1       = IW'(ring_add(int'(head), 1, DEPTH));
    assign disp_ready = (count != CW'(DEPTH)) && !flush_req;
    assign alloc_en   = disp_valid && disp_ready;
    assign disp_tag   = tail;

    cq_entry_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (alloc_en),
        .alloc_cls   (disp_class),
        .alloc_only  (disp_oldest_only),
        .alloc_pc    (disp_pc),
        .fin_valid   (fin_valid),
        .fin_idx     (fin_tag),
        .retire_n    (cmp_count),
        .flush       (flush_req),
        .valid_o     (valid),
        .done_o      (done),
        .cls_o       (cls),
        .only_o      (only),
        .pc_o        (pc),
        .head_o      (head),
        .tail_o      (tail),
        .count_o     (count),
        .count_nxt_o (count_nxt)
    );

    cq_head_fsm u_head (
        .clk          (clk),
        .rst_n        (rst_n),
        .nxt_nonempty (count_nxt != '0),
        .head_moves   (cmp_count != 2'd0),
        .head_aged    (head_aged)
    );

    cq_retire_logic #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_retire (
        .v0           (valid[head]),
        .f0           (done[head]),
        .cls0         (cls[head]),
        .pc0          (pc[head]),
        .v1           (valid[pos1]),
        .f1           (done[pos1]),
        .cls1         (cls[pos1]),
        .only1        (only[pos1]),
        .pc1          (pc[pos1]),
        .retire_n     (cmp_count),
        .store_commit (store_commit),
        .flush        (flush_req),
        .flush_pc     (flush_pc)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_exec
        logic is_moveto;
        assign is_moveto      = (ser_class_e'(cls[i]) == SC_MOVETO);
        assign moveto_mask[i] = valid[i] && is_moveto;
        assign exec_en[i]     = valid[i] && !done[i]
                              && (!is_moveto || (head == IW'(i) && head_aged));
    end

    // Completion begins only at a present, finished oldest entry.
    assert_head_finished_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_count != 2'd0) |-> (valid[head] && done[head]));

    // Never two store completions together.
    assert_one_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_count == 2'd2) |->
            !(ser_class_e'(cls[head]) == SC_STORE && ser_class_e'(cls[pos1]) == SC_STORE));

    // Oldest-only store never completes from the second slot.
    assert_oldest_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_count == 2'd2) |-> !(only[pos1] && ser_class_e'(cls[pos1]) == SC_STORE));

    // A commit strobe always accompanies a completion.
    assert_commit_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_commit |-> (cmp_count != 2'd0));

    // Full queue refuses dispatch.
    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !disp_ready);

    // A move-to starts only after a full cycle as oldest with no retirement.
    assert_moveto_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(exec_en & moveto_mask)) |->
            ($past(count) != '0 && $past(cmp_count) == 2'd0 && !$past(flush_req)));

endmodule

// File: tb/test_cq_serial_gate.sv
module test_cq_serial_gate;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic        dv;
        logic [1:0]  cls;
        logic        only;
        logic        fv;
        logic [2:0]  fidx;
        logic [1:0]  cmp;
        logic        com;
        logic        fl;
        logic [7:0]  ex;
        logic [31:0] fpc;
    } vec_t;

    localparam int NV = 36;
    // classes: 0 none, 1 move-to, 2 refetch, 3 store
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 32'h0},    // 0  s0 none
        '{1'b1, 2'd1, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 8'h01, 32'h0},    // 1  s1 move-to
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0, 8'h00, 32'h0},    // 2  s2; s0 retires
        '{1'b1, 2'd3, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h04, 32'h0},    // 3  s3 store; s1 fresh
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 8'h0E, 32'h0},    // 4  s1 aged
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 8'h0A, 32'h0},    // 5
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd3, 2'd2, 1'b0, 1'b0, 8'h08, 32'h0},    // 6  two retire
        '{1'b1, 2'd3, 1'b1, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0, 8'h00, 32'h0},    // 7  s4 store only
        '{1'b1, 2'd3, 1'b0, 1'b1, 3'd4, 2'd0, 1'b0, 1'b0, 8'h10, 32'h0},    // 8  s5 store
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd5, 2'd1, 1'b1, 1'b0, 8'h20, 32'h0},    // 9
        '{1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0, 8'h00, 32'h0},    // 10
        '{1'b1, 2'd3, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 32'h0},    // 11 s6 store
        '{1'b1, 2'd3, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h40, 32'h0},    // 12 s7 store
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd7, 2'd0, 1'b0, 1'b0, 8'hC0, 32'h0},    // 13
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd6, 2'd0, 1'b0, 1'b0, 8'h40, 32'h0},    // 14
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0, 8'h00, 32'h0},    // 15 one store only
        '{1'b1, 2'd2, 1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0, 8'h01, 32'h0},    // 16 s1 refetch
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 8'h03, 32'h0},    // 17
        '{1'b1, 2'd0, 1'b0, 1'b1, 3'd1, 2'd1, 1'b0, 1'b0, 8'h02, 32'h0},    // 18 s2
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 1'b1, 8'h04, 32'h1044}, // 19 flush pos0
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 32'h0},    // 20 s2 reused
        '{1'b1, 2'd2, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h04, 32'h0},    // 21 s3 refetch
        '{1'b1, 2'd0, 1'b0, 1'b1, 3'd3, 2'd0, 1'b0, 1'b0, 8'h0C, 32'h0},    // 22 s4
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 8'h14, 32'h0},    // 23
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0, 1'b1, 8'h10, 32'h1058}, // 24 flush pos1
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 32'h0},    // 25 s4 none
        '{1'b1, 2'd3, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h10, 32'h0},    // 26 s5 store only
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd5, 2'd0, 1'b0, 1'b0, 8'h30, 32'h0},    // 27
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd4, 2'd0, 1'b0, 1'b0, 8'h10, 32'h0},    // 28
        '{1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 1'b0, 8'h00, 32'h0},    // 29 only-store held
        '{1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 1'b0, 8'h00, 32'h0},    // 30
        '{1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h00, 32'h0},    // 31 s6 none
        '{1'b1, 2'd3, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 8'h40, 32'h0},    // 32 s7 store
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd7, 2'd0, 1'b0, 1'b0, 8'hC0, 32'h0},    // 33
        '{1'b0, 2'd0, 1'b0, 1'b1, 3'd6, 2'd0, 1'b0, 1'b0, 8'h40, 32'h0},    // 34
        '{1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 2'd2, 1'b1, 1'b0, 8'h00, 32'h0}     // 35 none + store
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [1:0]  disp_class = 2'd0;
    logic        disp_oldest_only = 1'b0;
    logic [31:0] disp_pc = 32'h0;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        fin_valid = 1'b0;
    logic [2:0]  fin_tag = 3'd0;
    logic [7:0]  exec_en;
    logic [1:0]  cmp_count;
    logic        store_commit;
    logic        flush_req;
    logic [31:0] flush_pc;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    cq_serial_gate i_cq_serial_gate (
        .clk              (clk),
        .rst_n            (rst_n),
        .disp_valid       (disp_valid),
        .disp_class       (disp_class),
        .disp_oldest_only (disp_oldest_only),
        .disp_pc          (disp_pc),
        .disp_ready       (disp_ready),
        .disp_tag         (disp_tag),
        .fin_valid        (fin_valid),
        .fin_tag          (fin_tag),
        .exec_en          (exec_en),
        .cmp_count        (cmp_count),
        .store_commit     (store_commit),
        .flush_req        (flush_req),
        .flush_pc         (flush_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "exec_en", 32'(exec_en), 32'h0);
        chk(req, "cmp_count", 32'(cmp_count), 32'h0);
        chk(req, "store_commit", 32'(store_commit), 32'h0);
        chk(req, "flush_req", 32'(flush_req), 32'h0);
        chk(req, "disp_ready", 32'(disp_ready), 32'h1);
    endtask

    initial begin
        #(CLK_P * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #2 chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        #2 chk_idle("R1");

        // Table walk: R3 R4 R5 R6 R7 R8 R9, readiness R2
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            disp_valid       = TBL[k].dv;
            disp_class       = TBL[k].cls;
            disp_oldest_only = TBL[k].only;
            disp_pc          = 32'h1000 + 32'(k * 4);
            fin_valid        = TBL[k].fv;
            fin_tag          = TBL[k].fidx;
            #2;
            chk($sformatf("R3/R4 step %0d", k), "exec_en", 32'(exec_en), 32'(TBL[k].ex));
            chk($sformatf("R5/R6/R7 step %0d", k), "cmp_count", 32'(cmp_count), 32'(TBL[k].cmp));
            chk($sformatf("R8 step %0d", k), "store_commit", 32'(store_commit), 32'(TBL[k].com));
            chk($sformatf("R9 step %0d", k), "flush_req", 32'(flush_req), 32'(TBL[k].fl));
            chk($sformatf("R2 step %0d", k), "disp_ready", 32'(disp_ready), 32'(!TBL[k].fl));
            if (TBL[k].fl) chk($sformatf("R9 step %0d", k), "flush_pc", flush_pc, TBL[k].fpc);
        end

        // R2: fill from empty, tags in ring order, then full
        @(negedge clk);
        disp_valid = 1'b0;
        fin_valid  = 1'b0;
        #2 chk("R2", "tag after drain", 32'(disp_tag), 32'h0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            disp_valid = 1'b1;
            disp_class = 2'd0;
            #2;
            chk("R2", "disp_tag fill", 32'(disp_tag), 32'(k));
            chk("R2", "disp_ready fill", 32'(disp_ready), 32'h1);
        end
        @(negedge clk);
        disp_valid = 1'b0;
        #2;
        chk("R2", "disp_ready full", 32'(disp_ready), 32'h0);
        chk("R3", "exec_en full", 32'(exec_en), 32'hFF);

        // R1: reset mid-run returns to idle
        rst_n = 1'b0;
        #2 chk_idle("R1");
        @(negedge clk);
        rst_n = 1'b1;
        #2 chk_idle("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule